// File: doc/BRIEF.md
# Legacy Peripheral Configuration Port

This block is a two-byte configuration window on the host I/O bus. The first byte is the index. A byte written there picks one of 256 internal byte registers. The second byte is the data window, which reads or writes whichever register the index currently points at. The register contents set which legacy peripherals are switched on: two serial ports, one parallel port and a floppy controller. They also set where each peripheral's I/O range starts. The block drives those enables and 10-bit base addresses straight to the peripheral decoders, which sit outside this block.

The port answers only while a port-enable level from the parent bridge is high, and only for the two addresses at its decode base. Other accesses leave every register untouched and return nothing. A read answers one cycle after its strobe, as a one-cycle `rd_valid` pulse with the byte on `rd_data`.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the index is 0x00 and the outputs are as follows. The parallel port is off. Both serial ports are on. The floppy controller is off. The bases are floppy 0x3F0, parallel 0x378, serial 0 0x3F8 and serial 1 0x2F8. `rd_valid` is low.
- R2: A write to the even address (0x3F0) loads the index. A read of the even address returns the current index.
- R3: A read or write of the odd address (0x3F1) reaches the register selected by the index. Indices with no function still store what is written and read it back.
- R4: A read of the odd address while the index is 0x00 returns 0x00.
- R5: Register 0xE0 is read-only and always reads 0x3C. A write to it changes nothing.
- R6: The function-select register sits at 0xE2 and resets to 0x0F. The parallel port is off only when bits 1:0 are both 1. Serial port n is on when bit n+2 is 1. The floppy controller is on when bit 4 is 1.
- R7: The base registers are floppy at 0xE3, parallel at 0xE6, serial 0 at 0xE7 and serial 1 at 0xE8. Each holds address bits 9:2, so each base output equals the stored byte shifted left by two.
- R8: While `port_en` is low, writes are ignored and reads give no `rd_valid`.
- R9: Addresses other than 0x3F0 and 0x3F1 are ignored: no register changes and no read response.
- R10: An accepted read raises `rd_valid` for exactly the next cycle, with the data on `rd_data`. A rejected read leaves `rd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable level from the parent bridge |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read response pulse |
| rd_data | output | 8 | Read response byte |
| par_en | output | 1 | Parallel port enable |
| ser_en | output | 2 | Serial port enables, bit n for port n |
| fdc_en | output | 1 | Floppy controller enable |
| par_base | output | 10 | Parallel port I/O base |
| fdc_base | output | 10 | Floppy controller I/O base |
| ser_base | output | 20 | Serial port I/O bases, port n in bits 10n+9:10n |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high in the same cycle. They also assume that each strobe lasts exactly one cycle, so that every read response can be traced to a single strobe. The stimulus drives every access through tasks that raise one strobe for one cycle and drop it before the next access. Accesses are made only after the synchronised reset has been released, and they include off-window addresses and disabled-port cycles, which the same rules cover.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] IDX_DEVID = 8'hE0;
  localparam logic [7:0] IDX_FSEL  = 8'hE2;
  localparam logic [7:0] IDX_FDC   = 8'hE3;
  localparam logic [7:0] IDX_PAR   = 8'hE6;
  localparam logic [7:0] IDX_SER0  = 8'hE7;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_INDEX = 2'd1,
    ACC_DATA  = 2'd2
  } acc_kind_e;

  // register address of serial port n base
  function automatic logic [7:0] ser_idx(input int unsigned n);
    return IDX_SER0 + 8'(n);
  endfunction

  function automatic logic [7:0] reg_reset_val(input int unsigned idx);
    logic [7:0] v;
    case (idx)
      32'hE0:  v = 8'h3C;
      32'hE2:  v = 8'h0F;
      32'hE3:  v = 8'hFC;
      32'hE6:  v = 8'hDE;
      32'hE7:  v = 8'hFE;
      32'hE8:  v = 8'hBE;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic logic reg_is_ro(input int unsigned idx);
    return idx == 32'(IDX_DEVID);
  endfunction

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic              port_en,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output acc_kind_e         acc_kind,
  output logic              acc_wr,
  output logic              acc_rd
);

  logic hit;

  always_comb begin
    hit = port_en && (io_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
    if (!hit)
      acc_kind = ACC_NONE;
    else if (io_addr[0])
      acc_kind = ACC_DATA;
    else
      acc_kind = ACC_INDEX;
    acc_wr = hit && io_wr;
    acc_rd = hit && io_rd;
  end

endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
  import sio_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 256,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (reg_is_ro(i)) begin : g_ro
      assign regs_flat[i*BYTE_W +: BYTE_W] = reg_reset_val(i);
    end else begin : g_rw
      logic [BYTE_W-1:0] q;
      logic [BYTE_W-1:0] d;
      logic              ce;

      always_comb begin
        ce = wr_en && (wr_idx == IDX_W'(i));
        d  = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= reg_reset_val(i);
        else if (ce)
          q <= d;
      end

      assign regs_flat[i*BYTE_W +: BYTE_W] = q;
    end
  end

endmodule

// File: rtl/sio_func_map.sv
module sio_func_map
  import sio_cfg_pkg::*;
#(
  parameter int unsigned NUM_SER = 2,
  localparam int unsigned BASE_W = BYTE_W + 2
) (
  input  logic [BYTE_W-1:0]         fsel,
  input  logic [BYTE_W-1:0]         fdc_byte,
  input  logic [BYTE_W-1:0]         par_byte,
  input  logic [NUM_SER*BYTE_W-1:0] ser_bytes,
  output logic                      par_en,
  output logic [NUM_SER-1:0]        ser_en,
  output logic                      fdc_en,
  output logic [BASE_W-1:0]         par_base,
  output logic [BASE_W-1:0]         fdc_base,
  output logic [NUM_SER*BASE_W-1:0] ser_base
);

  always_comb begin
    par_en   = (fsel[1:0] != 2'b11);
    fdc_en   = fsel[4];
    par_base = {par_byte, 2'b00};
    fdc_base = {fdc_byte, 2'b00};
  end

  for (genvar n = 0; n < NUM_SER; n++) begin : g_ser
    assign ser_en[n] = fsel[n+2];
    assign ser_base[n*BASE_W +: BASE_W] = {ser_bytes[n*BYTE_W +: BYTE_W], 2'b00};
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int unsigned NUM_SER   = 2,
  parameter int unsigned NUM_REGS  = 256,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned BASE_W   = BYTE_W + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      port_en,
  input  logic [ADDR_W-1:0]         io_addr,
  input  logic                      io_wr,
  input  logic                      io_rd,
  input  logic [BYTE_W-1:0]         io_wdata,
  output logic                      rd_valid,
  output logic [BYTE_W-1:0]         rd_data,
  output logic                      par_en,
  output logic [NUM_SER-1:0]        ser_en,
  output logic                      fdc_en,
  output logic [BASE_W-1:0]         par_base,
  output logic [BASE_W-1:0]         fdc_base,
  output logic [NUM_SER*BASE_W-1:0] ser_base
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe_q <= 2'b00;
    else
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  acc_kind_e acc_kind;
  logic      acc_wr;
  logic      acc_rd;

  sio_port_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dec (
    .port_en  (port_en),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .acc_kind (acc_kind),
    .acc_wr   (acc_wr),
    .acc_rd   (acc_rd)
  );

  logic [NUM_REGS*BYTE_W-1:0] regs_flat;
  logic [IDX_W-1:0]           idx_q;
  logic [IDX_W-1:0]           wr_idx;
  logic [BYTE_W-1:0]          sel_byte;

  assign idx_q = regs_flat[IDX_W-1:0];

  always_comb begin
    wr_idx   = (acc_kind == ACC_INDEX) ? '0 : idx_q;
    sel_byte = regs_flat[{idx_q, 3'b000} +: BYTE_W];
  end

  sio_reg_bank #(
    .NUM_REGS (NUM_REGS)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (acc_wr),
    .wr_idx    (wr_idx),
    .wr_data   (io_wdata),
    .regs_flat (regs_flat)
  );

  // read response path
  logic              rd_valid_d;
  logic [BYTE_W-1:0] rd_data_d;
  logic              rd_data_ce;

  always_comb begin
    rd_valid_d = acc_rd;
    rd_data_ce = acc_rd;
    if (acc_kind == ACC_INDEX)
      rd_data_d = BYTE_W'(idx_q);
    else if (idx_q == '0)
      rd_data_d = '0;
    else
      rd_data_d = sel_byte;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_valid_d;
      if (rd_data_ce)
        rd_data <= rd_data_d;
    end
  end

  // peripheral controls
  logic [NUM_SER*BYTE_W-1:0] ser_bytes;

  for (genvar n = 0; n < NUM_SER; n++) begin : g_ser_pick
    assign ser_bytes[n*BYTE_W +: BYTE_W] = regs_flat[ser_idx(n)*BYTE_W +: BYTE_W];
  end

  sio_func_map #(
    .NUM_SER (NUM_SER)
  ) u_map (
    .fsel      (regs_flat[IDX_FSEL*BYTE_W +: BYTE_W]),
    .fdc_byte  (regs_flat[IDX_FDC*BYTE_W +: BYTE_W]),
    .par_byte  (regs_flat[IDX_PAR*BYTE_W +: BYTE_W]),
    .ser_bytes (ser_bytes),
    .par_en    (par_en),
    .ser_en    (ser_en),
    .fdc_en    (fdc_en),
    .par_base  (par_base),
    .fdc_base  (fdc_base),
    .ser_base  (ser_base)
  );

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int unsigned NUM_SER   = 2,
  parameter int unsigned IDX_W     = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  port_en,
  input logic [ADDR_W-1:0]     io_addr,
  input logic                  io_wr,
  input logic                  io_rd,
  input logic                  rd_valid,
  input logic [7:0]            rd_data,
  input logic                  par_en,
  input logic [NUM_SER-1:0]    ser_en,
  input logic                  fdc_en,
  input logic [9:0]            par_base,
  input logic [9:0]            fdc_base,
  input logic [NUM_SER*10-1:0] ser_base,
  input logic [IDX_W-1:0]      cur_idx
);

  logic hit;
  assign hit = port_en && (io_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);

  // R10
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit) |=> rd_valid);

  // R8
  no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && hit) |=> !rd_valid);

  // R9
  ctl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && hit) |=> $stable({par_en, ser_en, fdc_en, par_base, fdc_base, ser_base}));

  // R4
  idx0_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit && io_addr[0] && cur_idx == '0) |=> rd_data == 8'h00);

  // R5
  devid_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit && io_addr[0] && cur_idx == IDX_W'(8'hE0)) |=> rd_data == 8'h3C);

  // R2
  idx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit && !io_addr[0]) |=> rd_data == 8'($past(cur_idx)));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .NUM_SER   (NUM_SER),
  .IDX_W     (IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .port_en  (port_en),
  .io_addr  (io_addr),
  .io_wr    (io_wr),
  .io_rd    (io_rd),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .par_en   (par_en),
  .ser_en   (ser_en),
  .fdc_en   (fdc_en),
  .par_base (par_base),
  .fdc_base (fdc_base),
  .ser_base (ser_base),
  .cur_idx  (idx_q)
);

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;

  logic        clk;
  logic        rst_n;
  logic        port_en;
  logic [15:0] io_addr;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_wdata;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        par_en;
  logic [1:0]  ser_en;
  logic        fdc_en;
  logic [9:0]  par_base;
  logic [9:0]  fdc_base;
  logic [19:0] ser_base;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sio_cfg_port u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .par_en   (par_en),
    .ser_en   (ser_en),
    .fdc_en   (fdc_en),
    .par_base (par_base),
    .fdc_base (fdc_base),
    .ser_base (ser_base)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  // returns {valid, data} sampled one cycle after the strobe
  task automatic do_read(input logic [15:0] a, output logic [8:0] r);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    r = {rd_valid, rd_data};
  endtask

  // vector: {op[1:0], req[3:0], addr[15:0], data[7:0]}
  // op 1 write, 2 read expecting data, 3 read expecting no response
  localparam int NV = 17;
  localparam logic [29:0] VEC [NV] = '{
    {2'd2, 4'd2,  16'h03F0, 8'h00},  // R2 index after reset
    {2'd2, 4'd4,  16'h03F1, 8'h00},  // R4 data read with index 0
    {2'd1, 4'd2,  16'h03F0, 8'hE0},  // R2
    {2'd2, 4'd5,  16'h03F1, 8'h3C},  // R5
    {2'd1, 4'd5,  16'h03F1, 8'h55},  // R5 discarded write
    {2'd2, 4'd5,  16'h03F1, 8'h3C},  // R5
    {2'd2, 4'd2,  16'h03F0, 8'hE0},  // R2
    {2'd1, 4'd3,  16'h03F0, 8'h91},  // R3 unimplemented index
    {2'd1, 4'd3,  16'h03F1, 8'hA7},  // R3
    {2'd2, 4'd3,  16'h03F1, 8'hA7},  // R3
    {2'd1, 4'd3,  16'h03F0, 8'hE6},  // R3
    {2'd2, 4'd3,  16'h03F1, 8'hDE},  // R3 parallel base reset value
    {2'd1, 4'd9,  16'h03F2, 8'h12},  // R9 miss
    {2'd2, 4'd9,  16'h03F0, 8'hE6},  // R9 index untouched
    {2'd3, 4'd9,  16'h03F2, 8'h00},  // R9
    {2'd3, 4'd10, 16'h03EF, 8'h00},  // R10 rejected read
    {2'd2, 4'd10, 16'h03F1, 8'hDE}   // R10
  };

  initial begin : wd
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [8:0] r;
    port_en = 1'b1; io_addr = '0; io_wr = 0; io_rd = 0; io_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 par_en",   32'(par_en),   32'd0);
    check("R1 ser_en",   32'(ser_en),   32'd3);
    check("R1 fdc_en",   32'(fdc_en),   32'd0);
    check("R1 fdc_base", 32'(fdc_base), 32'h3F0);
    check("R1 par_base", 32'(par_base), 32'h378);
    check("R1 ser_base", 32'(ser_base), {12'h0, 10'h2F8, 10'h3F8});
    check("R1 rd_valid", 32'(rd_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [15:0] a;
      logic [7:0]  d;
      string       tag;
      {op, rq, a, d} = VEC[i];
      tag = $sformatf("R%0d vec%0d", rq, i);
      if (op == 2'd1) begin
        do_write(a, d);
      end else if (op == 2'd2) begin
        do_read(a, r);
        check(tag, 32'(r), {23'h0, 1'b1, d});
      end else begin
        do_read(a, r);
        check(tag, 32'(r[8]), 32'd0);
      end
    end

    // R6 function-select patterns
    do_write(16'h03F0, 8'hE2);
    do_write(16'h03F1, 8'h13);
    check("R6 fsel13", {29'h0, par_en, ser_en}, 32'b000);
    check("R6 fsel13 fdc", 32'(fdc_en), 32'd1);
    do_write(16'h03F1, 8'h02);
    check("R6 fsel02", {28'h0, fdc_en, par_en, ser_en}, 32'b0100);
    do_write(16'h03F1, 8'h0D);
    check("R6 fsel0D", {28'h0, fdc_en, par_en, ser_en}, 32'b0111);
    do_write(16'h03F1, 8'h09);
    check("R6 fsel09", {28'h0, fdc_en, par_en, ser_en}, 32'b0110);

    // R7 base shifts
    do_write(16'h03F0, 8'hE3);
    do_write(16'h03F1, 8'h12);
    check("R7 fdc_base", 32'(fdc_base), 32'h048);
    do_write(16'h03F0, 8'hE7);
    do_write(16'h03F1, 8'hFF);
    do_write(16'h03F0, 8'hE8);
    do_write(16'h03F1, 8'h00);
    check("R7 ser_base", 32'(ser_base), {12'h0, 10'h000, 10'h3FC});
    do_write(16'h03F0, 8'hE6);
    do_write(16'h03F1, 8'h01);
    check("R7 par_base", 32'(par_base), 32'h004);

    // R8 disabled port
    port_en = 1'b0;
    do_write(16'h03F1, 8'h77);
    do_read(16'h03F1, r);
    check("R8 no response", 32'(r[8]), 32'd0);
    check("R8 par_base kept", 32'(par_base), 32'h004);
    port_en = 1'b1;
    do_read(16'h03F1, r);
    check("R8 reg kept", 32'(r), {23'h0, 1'b1, 8'h01});

    // R10 pulse lasts one cycle
    @(negedge clk);
    check("R10 single pulse", 32'(rd_valid), 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule